// File: doc/BRIEF.md
# UART FIFO Control and Trigger Unit

This block holds the transmit and receive byte queues of a 16550-compatible serial port, together with the control word that configures them. One 8-bit control write sets a global queue enable, fires one-shot flushes of either queue, picks one of two DMA signalling modes and sets a two-bit trigger level for each direction. The serializer, the deserializer, baud timing, parity and line status are outside this block. It meets them through push and pop strobes, one pair per queue.

The occupancy counts drive two trigger flags and two DMA request lines. The transmit trigger field and the receive trigger field list the same four thresholds in opposite orders. When the enable bit is clear, each direction becomes a single-byte holding register. In that state both trigger flags simply report whether the holding register is occupied.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the control word reads 0x00, both counts are 0, both trigger flags are 0, rx_dma_req is 0 and tx_dma_req is 1.
- R2: Control bit 0 sets the capacity of each queue: DEPTH entries when it is 1, one entry when it is 0. A control write that changes bit 0 also empties both queues. The full flag is high when the count equals the capacity.
- R3: A control write with bit 1 set empties the receive queue, so rx_count is 0 in the next cycle. Bit 1 always reads back as 0.
- R4: A control write with bit 2 set empties the transmit queue, so tx_count is 0 in the next cycle. Bit 2 always reads back as 0.
- R5: A flush takes priority over a push or a pop in the same cycle. The queue is empty afterwards and the read data is unchanged.
- R6: Bytes leave each queue in the order they entered. A push is accepted only when the count before the edge is below the capacity; any other push is dropped. The read data register loads the head byte on the edge of an accepted pop. A pop from an empty queue leaves the count and the read data unchanged.
- R7: With the queues enabled, tx_trig is high when tx_count is greater than a threshold chosen by control bits 5:4. The encodings are 0 for 16, 1 for 8, 2 for 4 and 3 for 1.
- R8: With the queues enabled, rx_trig is high when rx_count is greater than a threshold chosen by control bits 7:6. The encodings are 0 for 1, 1 for 4, 2 for 8 and 3 for 16.
- R9: With the queues disabled, each trigger flag is high exactly when its holding register is occupied (count 1).
- R10: Control bit 3 selects the DMA mode. In mode 0, rx_dma_req is high whenever the receive queue holds at least one byte. In mode 1, rx_dma_req rises with rx_trig and stays high until the receive queue is empty.
- R11: In mode 0, tx_dma_req is high when the transmit queue is empty. In mode 1, it is high while the transmit count is below the current capacity.
- R12: The control word reads back bits 7:3 and bit 0 as last written, one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word readback, flush bits read 0 |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop the head of the transmit queue |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 6 | Transmit queue occupancy |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| tx_trig | output | 1 | Transmit trigger flag |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_wdata | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop the head of the receive queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 6 | Receive queue occupancy |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_trig | output | 1 | Receive trigger flag |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with its default DEPTH of 32 and 8-bit data. At that depth, the largest threshold of 16 and a completely full queue are both a short burst of pushes away. This lets every trigger encoding be tested one count below and one count at its crossing. It also lets drops at capacity occur many times during random traffic. Random control writes move the block between enabled, disabled and both DMA modes in the middle of traffic, so flushes caused by toggling the enable bit collide with pushes and pops.

// File: rtl/uart_fifo_pkg.sv
`timescale 1ns/1ps
package uart_fifo_pkg;
    // Registered view of the control word (flush bits are not stored)
    typedef struct packed {
        logic [1:0] rx_lvl;
        logic [1:0] tx_lvl;
        logic       dma_sel;
        logic       en;
    } fcfg_t;
endpackage

// File: rtl/fifo_cfg_reg.sv
`timescale 1ns/1ps
module fifo_cfg_reg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output fcfg_t      cfg,
    output logic       flush_tx,
    output logic       flush_rx,
    output logic [7:0] rdback
);
    typedef struct packed {
        fcfg_t cfg;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        flush_tx = 1'b0;
        flush_rx = 1'b0;
        if (we) begin
            s_d.cfg.en      = wdata[0];
            s_d.cfg.dma_sel = wdata[3];
            s_d.cfg.tx_lvl  = wdata[5:4];
            s_d.cfg.rx_lvl  = wdata[7:6];
            // Toggling the enable bit resets both queues
            flush_rx = wdata[1] | (wdata[0] != s_q.cfg.en);
            flush_tx = wdata[2] | (wdata[0] != s_q.cfg.en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg    = s_q.cfg;
    assign rdback = {s_q.cfg.rx_lvl, s_q.cfg.tx_lvl, s_q.cfg.dma_sel, 2'b00, s_q.cfg.en};
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
module fifo_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              din,
    input  logic                       pop,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic [DW-1:0]            dout;
    } st_t;

    st_t s_d, s_q;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        cap     = en ? CW'(DEPTH) : CW'(1);
        do_push = push && (s_q.cnt < cap);
        do_pop  = pop && (s_q.cnt != '0);
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = din;
                s_d.wp          = ptr_inc(s_q.wp);
            end
            if (do_pop) begin
                s_d.dout = s_q.mem[s_q.rp];
                s_d.rp   = ptr_inc(s_q.rp);
            end
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout  = s_q.dout;
    assign cnt   = s_q.cnt;
    assign full  = (s_q.cnt == cap);
    assign empty = (s_q.cnt == '0);
endmodule

// File: rtl/fifo_trig.sv
`timescale 1ns/1ps
module fifo_trig
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  fcfg_t                      cfg,
    input  logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input  logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    output logic                       tx_trig,
    output logic                       rx_trig,
    output logic                       tx_dreq,
    output logic                       rx_dreq
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic rx_hold;
    } st_t;

    st_t s_d, s_q;
    logic [CW-1:0] tx_thr, rx_thr, cap;
    logic          rx_ne;

    always_comb begin
        // Transmit field: larger code, lower threshold
        case (cfg.tx_lvl)
            2'd0:    tx_thr = CW'(16);
            2'd1:    tx_thr = CW'(8);
            2'd2:    tx_thr = CW'(4);
            default: tx_thr = CW'(1);
        endcase
        // Receive field: larger code, higher threshold
        case (cfg.rx_lvl)
            2'd0:    rx_thr = CW'(1);
            2'd1:    rx_thr = CW'(4);
            2'd2:    rx_thr = CW'(8);
            default: rx_thr = CW'(16);
        endcase
        cap     = cfg.en ? CW'(DEPTH) : CW'(1);
        rx_ne   = (rx_cnt != '0);
        tx_trig = cfg.en ? (tx_cnt > tx_thr) : (tx_cnt != '0);
        rx_trig = cfg.en ? (rx_cnt > rx_thr) : rx_ne;

        s_d.rx_hold = cfg.dma_sel & (rx_trig | (s_q.rx_hold & rx_ne));
        rx_dreq     = cfg.dma_sel ? (rx_trig | (s_q.rx_hold & rx_ne)) : rx_ne;
        tx_dreq     = cfg.dma_sel ? (tx_cnt < cap) : (tx_cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_fifo_ctl.sv
`timescale 1ns/1ps
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [7:0]                 cfg_wdata,
    output logic [7:0]                 cfg_rdata,
    input  logic                       tx_push,
    input  logic [DW-1:0]              tx_wdata,
    input  logic                       tx_pop,
    output logic [DW-1:0]              tx_rdata,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic                       tx_full,
    output logic                       tx_empty,
    output logic                       tx_trig,
    output logic                       tx_dma_req,
    input  logic                       rx_push,
    input  logic [DW-1:0]              rx_wdata,
    input  logic                       rx_pop,
    output logic [DW-1:0]              rx_rdata,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       rx_full,
    output logic                       rx_empty,
    output logic                       rx_trig,
    output logic                       rx_dma_req
);
    fcfg_t cfg;
    logic  flush_tx, flush_rx;

    fifo_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg      (cfg),
        .flush_tx (flush_tx),
        .flush_rx (flush_rx),
        .rdback   (cfg_rdata)
    );

    fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg.en),
        .flush (flush_tx),
        .push  (tx_push),
        .din   (tx_wdata),
        .pop   (tx_pop),
        .dout  (tx_rdata),
        .cnt   (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg.en),
        .flush (flush_rx),
        .push  (rx_push),
        .din   (rx_wdata),
        .pop   (rx_pop),
        .dout  (rx_rdata),
        .cnt   (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    fifo_trig #(.DEPTH(DEPTH)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .tx_cnt  (tx_count),
        .rx_cnt  (rx_count),
        .tx_trig (tx_trig),
        .rx_trig (rx_trig),
        .tx_dreq (tx_dma_req),
        .rx_dreq (rx_dma_req)
    );
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
`timescale 1ns/1ps
module uart_fifo_ctl_chk #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic [7:0]                 cfg_wdata,
    input logic [7:0]                 cfg_rdata,
    input logic                       tx_push,
    input logic                       tx_pop,
    input logic [$clog2(DEPTH+1)-1:0] tx_count,
    input logic                       tx_full,
    input logic                       tx_empty,
    input logic                       tx_trig,
    input logic                       rx_push,
    input logic                       rx_pop,
    input logic [DW-1:0]              rx_rdata,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic                       rx_empty,
    input logic                       rx_trig,
    input logic                       rx_dma_req
);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= DEPTH) && (rx_count <= DEPTH));

    a_r2_disabled_single: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |-> (tx_count <= 1) && (rx_count <= 1));

    a_r2_toggle_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_wdata[0] != cfg_rdata[0]) |=> (tx_count == 0) && (rx_count == 0));

    a_r3_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[1] |=> rx_count == 0);

    a_r4_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[2] |=> tx_count == 0);

    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we && tx_full && tx_push && !tx_pop |=> $stable(tx_count));

    a_r6_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we && rx_empty && rx_pop && !rx_push |=> (rx_count == 0) && $stable(rx_rdata));

    a_r9_single_trig: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |-> (tx_trig == !tx_empty) && (rx_trig == !rx_empty));

    a_r10_mode0_rx_req: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[3] |-> rx_dma_req == !rx_empty);

    a_r12_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == {$past(cfg_wdata[7:3]), 2'b00, $past(cfg_wdata[0])});
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/tb_uart_fifo_ctl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctl;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, cfg_we;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic       tx_push, tx_pop, rx_push, rx_pop;
    logic [7:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
    logic [5:0] tx_count, rx_count;
    logic       tx_full, tx_empty, tx_trig, tx_dma_req;
    logic       rx_full, rx_empty, rx_trig, rx_dma_req;

    uart_fifo_ctl #(.DEPTH(DEPTH), .DW(8)) dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model
    byte unsigned q_tx[$];
    byte unsigned q_rx[$];
    logic [7:0]   m_cfg = 8'h00;
    logic [7:0]   m_txd = 8'h00;
    logic [7:0]   m_rxd = 8'h00;
    bit           m_hold = 0;

    function automatic int thr_tx(input logic [1:0] e);
        case (e) 2'd0: return 16; 2'd1: return 8; 2'd2: return 4; default: return 1; endcase
    endfunction
    function automatic int thr_rx(input logic [1:0] e);
        case (e) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 16; endcase
    endfunction
    function automatic int cap();
        return m_cfg[0] ? DEPTH : 1;
    endfunction
    function automatic bit exp_ttrig();
        return m_cfg[0] ? (q_tx.size() > thr_tx(m_cfg[5:4])) : (q_tx.size() != 0);
    endfunction
    function automatic bit exp_rtrig();
        return m_cfg[0] ? (q_rx.size() > thr_rx(m_cfg[7:6])) : (q_rx.size() != 0);
    endfunction
    function automatic bit exp_rreq();
        return m_cfg[3] ? (exp_rtrig() || (m_hold && q_rx.size() != 0)) : (q_rx.size() != 0);
    endfunction
    function automatic bit exp_treq();
        return m_cfg[3] ? (q_tx.size() < cap()) : (q_tx.size() == 0);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R6 tx_count", tx_count, q_tx.size());
        chk("R6 rx_count", rx_count, q_rx.size());
        chk("R2 tx_full", tx_full, q_tx.size() == cap());
        chk("R2 rx_full", rx_full, q_rx.size() == cap());
        chk("R6 tx_empty", tx_empty, q_tx.size() == 0);
        chk("R6 rx_empty", rx_empty, q_rx.size() == 0);
        chk(m_cfg[0] ? "R7 tx_trig" : "R9 tx_trig", tx_trig, exp_ttrig());
        chk(m_cfg[0] ? "R8 rx_trig" : "R9 rx_trig", rx_trig, exp_rtrig());
        chk("R10 rx_dma_req", rx_dma_req, exp_rreq());
        chk("R11 tx_dma_req", tx_dma_req, exp_treq());
        chk("R12 cfg_rdata", cfg_rdata, m_cfg);
        chk("R6 tx_rdata", tx_rdata, m_txd);
        chk("R6 rx_rdata", rx_rdata, m_rxd);
    endtask

    // Called just after a falling edge: drive, advance model, wait one cycle, compare
    task automatic step(input bit tp, input logic [7:0] td, input bit tpo,
                        input bit rp, input logic [7:0] rd, input bit rpo,
                        input bit we, input logic [7:0] wd);
        int  c      = cap();
        bit  fl_rx  = we && (wd[1] || (wd[0] != m_cfg[0]));
        bit  fl_tx  = we && (wd[2] || (wd[0] != m_cfg[0]));
        bit  nhold  = m_cfg[3] && (exp_rtrig() || (m_hold && q_rx.size() != 0));
        tx_push = tp; tx_wdata = td; tx_pop = tpo;
        rx_push = rp; rx_wdata = rd; rx_pop = rpo;
        cfg_we  = we; cfg_wdata = wd;
        if (fl_tx) q_tx.delete();
        else begin
            bit pa = tp && (q_tx.size() < c);
            bit po = tpo && (q_tx.size() != 0);
            if (po) m_txd = q_tx.pop_front();
            if (pa) q_tx.push_back(td);
        end
        if (fl_rx) q_rx.delete();
        else begin
            bit pa = rp && (q_rx.size() < c);
            bit po = rpo && (q_rx.size() != 0);
            if (po) m_rxd = q_rx.pop_front();
            if (pa) q_rx.push_back(rd);
        end
        m_hold = nhold;
        if (we) m_cfg = {wd[7:3], 2'b00, wd[0]};
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; cfg_we = 0;
        check_all();
    endtask

    task automatic wr(input logic [7:0] wd);
        step(0, 8'h00, 0, 0, 8'h00, 0, 1, wd);
    endtask
    task automatic push_rx(input logic [7:0] d);
        step(0, 8'h00, 0, 1, d, 0, 0, 8'h00);
    endtask
    task automatic push_tx(input logic [7:0] d);
        step(1, d, 0, 0, 8'h00, 0, 0, 8'h00);
    endtask
    task automatic pop_rx();
        step(0, 8'h00, 0, 0, 8'h00, 1, 0, 8'h00);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        rst_n = 0; cfg_we = 0; cfg_wdata = 0;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; tx_wdata = 0; rx_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 cfg_rdata", cfg_rdata, 0);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_trig", tx_trig, 0);
        chk("R1 rx_trig", rx_trig, 0);
        chk("R1 rx_dma_req", rx_dma_req, 0);
        chk("R1 tx_dma_req", tx_dma_req, 1);

        // R8 receive threshold boundaries for all four codes
        for (int e = 0; e < 4; e++) begin
            wr({e[1:0], 2'b00, 1'b0, 2'b11, 1'b1});
            for (int i = 0; i < thr_rx(e[1:0]); i++) push_rx(8'(i + 1));
            chk("R8 rx_trig at threshold", rx_trig, 0);
            push_rx(8'hA5);
            chk("R8 rx_trig above threshold", rx_trig, 1);
        end
        // R7 transmit threshold boundaries for all four codes
        for (int e = 0; e < 4; e++) begin
            wr({2'b00, e[1:0], 1'b0, 2'b11, 1'b1});
            for (int i = 0; i < thr_tx(e[1:0]); i++) push_tx(8'(i + 7));
            chk("R7 tx_trig at threshold", tx_trig, 0);
            push_tx(8'h5A);
            chk("R7 tx_trig above threshold", tx_trig, 1);
        end

        // R6 fill to capacity, drop overflow, drain in order, pop when empty
        wr(8'b0000_0111);
        for (int i = 0; i < DEPTH + 2; i++) push_rx(8'(8'h40 + i));
        chk("R6 rx_count saturates", rx_count, DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_rx();
        chk("R6 last byte out", rx_rdata, 8'h40 + DEPTH - 1);
        pop_rx();
        chk("R6 empty pop keeps data", rx_rdata, 8'h40 + DEPTH - 1);

        // R5 R3 R4 flush during traffic
        for (int i = 0; i < 6; i++) step(1, 8'(i), 0, 1, 8'(i + 9), 0, 0, 8'h00);
        step(1, 8'h11, 1, 1, 8'h22, 1, 1, 8'b0000_0111);
        chk("R5 rx empty after flush", rx_count, 0);
        chk("R5 tx empty after flush", tx_count, 0);
        chk("R3 flush rx bit reads 0", cfg_rdata[1], 0);
        chk("R4 flush tx bit reads 0", cfg_rdata[2], 0);

        // R10 DMA mode 1 hold until empty
        wr(8'b0100_1001);
        for (int i = 0; i < 5; i++) push_rx(8'(i));
        chk("R10 mode1 req at trigger", rx_dma_req, 1);
        for (int i = 0; i < 4; i++) pop_rx();
        chk("R10 mode1 req held", rx_dma_req, 1);
        pop_rx();
        chk("R10 mode1 req drops on empty", rx_dma_req, 0);
        push_rx(8'h33);
        chk("R10 mode1 below trigger", rx_dma_req, 0);
        chk("R11 mode1 tx room", tx_dma_req, 1);

        // R9 R2 single-entry mode
        wr(8'b0000_0000);
        push_rx(8'h77); push_rx(8'h78);
        chk("R2 single entry count", rx_count, 1);
        chk("R9 single entry trig", rx_trig, 1);

        // Random traffic with occasional control writes
        for (int n = 0; n < 5000; n++) begin
            int  bias = (n / 400) % 2;
            bit  tp   = ($urandom % 4) < (bias ? 3 : 1);
            bit  tpo  = ($urandom % 4) < (bias ? 1 : 3);
            bit  rp   = ($urandom % 4) < (bias ? 3 : 1);
            bit  rpo  = ($urandom % 4) < (bias ? 1 : 3);
            bit  we   = ($urandom % 60) == 0;
            logic [7:0] wd = 8'($urandom);
            if (($urandom % 4) != 0) wd[0] = 1'b1;
            if (($urandom % 3) != 0) wd[2:1] = 2'b00;
            step(tp, 8'($urandom), tpo, rp, 8'($urandom), rpo, we, wd);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule